// File: doc/BRIEF.md
# Four-Channel DMA Controller Host Register File

This block is the host-facing register file of a four-channel DMA controller in the classic ISA style. A host reaches it through a byte-wide port bus that carries a 4-bit register offset, a read strobe and a write strobe. Each channel keeps a 16-bit start address and start count, plus working copies of both, and a 6-bit mode field. The controller as a whole keeps a command byte, a status byte, a request byte, a temporary byte and a 4-bit channel mask.

Each 16-bit address or count register is reached one byte at a time. A single shared byte pointer picks the low byte or the high byte and flips after each such access. Some write-only offsets do not store data but act at once: they clear the pointer, clear the mask, or perform a master reset.

A transfer engine sits beside the block. It reads the working registers, the start registers, the modes, the mask, the command and the request byte from flat output buses. It writes back new working address and count values for one channel at a time, sets and clears status bits, and loads the temporary byte.

Top module: `dmac_hostif`

## Requirements
- R1: While `rst` is high (synchronous, active-high) the mask becomes 4'hF. The byte pointer, command, status, request and temporary byte clear to zero, and every start, working and mode register of every channel clears to zero.
- R2: A write to offsets 0..7 selects channel offset[2:1]. Bit 0 of the offset chooses address (0) or count (1). The write loads `bus_wdata` into the byte chosen by the pointer (0 = bits 7:0, 1 = bits 15:8) of both the start copy and the working copy.
- R3: A read of offsets 0..7 returns the pointer-selected byte of the working copy, combinationally. Any read or write of offsets 0..7 flips the pointer. A write to offset 4'hC clears the pointer.
- R4: A write to offset 4'hB stores `bus_wdata[7:2]` as the mode of the channel named by `bus_wdata[1:0]`. Other channels keep their modes.
- R5: A write to offset 4'hA changes only mask bit `bus_wdata[1:0]`. It sets the bit when `bus_wdata[2]` is 1 and clears it when `bus_wdata[2]` is 0.
- R6: A write to offset 4'hF loads `bus_wdata[3:0]` into the mask. A read of offset 4'hF returns {4'h0, mask}. A write to offset 4'hE clears the whole mask.
- R7: A write to offset 4'hD is a master reset. On the next edge, command, status, request, temporary byte and pointer become 0 and the mask becomes 4'hF. Channel start, working and mode registers keep their values.
- R8: A read of offsets 9, A, B, C or E returns 8'hFF, and such a read does not move the pointer.
- R9: Offset 8 reads status and writes command (`eng_cmd`). A write to offset 9 loads the request byte (`eng_req`). A read of offset 4'hD returns the temporary byte, which `tmp_we`/`tmp_data` load.
- R10: When `upd_we` is high, channel `upd_ch` takes `upd_addr` and `upd_count` as its working values, and its start registers are left alone. If a host byte write hits the same working register in that cycle, the host byte replaces the matching byte of the engine value.
- R11: Each cycle, status becomes (status & ~`sts_clr`) | `sts_set`. A master reset in the same cycle wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Host register offset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte (combinational) |
| eng_cur_addr | output | 64 | Working address, channel c in bits [16c+15:16c] |
| eng_cur_count | output | 64 | Working count, per channel |
| eng_base_addr | output | 64 | Start address, per channel |
| eng_base_count | output | 64 | Start count, per channel |
| eng_mode | output | 24 | Mode field, channel c in bits [6c+5:6c] |
| eng_mask | output | 4 | Channel mask |
| eng_cmd | output | 8 | Command byte |
| eng_req | output | 8 | Request byte |
| eng_status | output | 8 | Status byte |
| upd_we | input | 1 | Engine working-register update strobe |
| upd_ch | input | 2 | Channel being updated |
| upd_addr | input | 16 | New working address |
| upd_count | input | 16 | New working count |
| sts_set | input | 8 | Status bits to set |
| sts_clr | input | 8 | Status bits to clear |
| tmp_we | input | 1 | Temporary byte load strobe |
| tmp_data | input | 8 | Temporary byte value |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is an engine write-back and a host byte write to the same working register. The bench provokes it by raising `upd_we` for channel 1 on the very cycle it writes the low address byte. It then expects the engine's high byte joined to the host's low byte in the working copy, and only the host byte in the start copy.

The second pair is a master reset and an engine status set. The bench provokes it by issuing the reset while `sts_set` is non-zero. It then expects a zero status readback, since the reset must win.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int unsigned NCH = 4;
    localparam int unsigned CHW = $clog2(NCH);
    localparam int unsigned DW  = 8;
    localparam int unsigned RW  = 2 * DW;
    localparam int unsigned MW  = DW - CHW;

    typedef enum logic [3:0] {
        OFF_STAT_CMD = 4'h8,
        OFF_REQUEST  = 4'h9,
        OFF_ONE_MASK = 4'hA,
        OFF_MODE     = 4'hB,
        OFF_PTR_CLR  = 4'hC,
        OFF_TMP_MRST = 4'hD,
        OFF_MASK_CLR = 4'hE,
        OFF_ALL_MASK = 4'hF
    } ctl_off_e;

    typedef struct packed {
        logic [RW-1:0] base_addr;
        logic [RW-1:0] cur_addr;
        logic [RW-1:0] base_cnt;
        logic [RW-1:0] cur_cnt;
        logic [MW-1:0] mode;
    } chan_regs_t;

    function automatic logic [RW-1:0] put_byte(input logic [RW-1:0] w,
                                               input logic hi,
                                               input logic [DW-1:0] b);
        return hi ? {b, w[DW-1:0]} : {w[RW-1:DW], b};
    endfunction

    function automatic logic [DW-1:0] get_byte(input logic [RW-1:0] w,
                                               input logic hi);
        return hi ? w[RW-1:DW] : w[DW-1:0];
    endfunction
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_addr_we,
    input  logic             host_cnt_we,
    input  logic             ptr,
    input  logic [DW-1:0]    wdata,
    input  logic             mode_we,
    input  logic [MW-1:0]    mode_val,
    input  logic             upd_we,
    input  logic [RW-1:0]    upd_addr,
    input  logic [RW-1:0]    upd_count,
    output chan_regs_t       regs
);
    chan_regs_t nxt;

    always_comb begin
        nxt = regs;
        if (upd_we) begin
            nxt.cur_addr = upd_addr;
            nxt.cur_cnt  = upd_count;
        end
        if (host_addr_we) begin
            nxt.cur_addr  = put_byte(nxt.cur_addr, ptr, wdata);
            nxt.base_addr = put_byte(regs.base_addr, ptr, wdata);
        end
        if (host_cnt_we) begin
            nxt.cur_cnt  = put_byte(nxt.cur_cnt, ptr, wdata);
            nxt.base_cnt = put_byte(regs.base_cnt, ptr, wdata);
        end
        if (mode_we)
            nxt.mode = mode_val;
    end

    always_ff @(posedge clk) begin
        if (rst) regs <= '0;
        else     regs <= nxt;
    end
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
    import dmac_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           ch_access,
    input  logic           ptr_clr,
    input  logic           mrst,
    input  logic           mask_clr,
    input  logic           cmd_we,
    input  logic           req_we,
    input  logic           one_mask_we,
    input  logic           all_mask_we,
    input  logic [DW-1:0]  wdata,
    input  logic [DW-1:0]  sts_set,
    input  logic [DW-1:0]  sts_clr,
    input  logic           tmp_we,
    input  logic [DW-1:0]  tmp_data,
    output logic           ptr,
    output logic [DW-1:0]  cmd,
    output logic [DW-1:0]  req,
    output logic [DW-1:0]  status,
    output logic [DW-1:0]  tmp,
    output logic [NCH-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst || mrst) begin
            ptr    <= 1'b0;
            cmd    <= '0;
            req    <= '0;
            status <= '0;
            tmp    <= '0;
            mask   <= '1;
        end else begin
            if (ptr_clr)        ptr <= 1'b0;
            else if (ch_access) ptr <= ~ptr;
            if (cmd_we) cmd <= wdata;
            if (req_we) req <= wdata;
            if (tmp_we) tmp <= tmp_data;
            status <= (status & ~sts_clr) | sts_set;
            if (mask_clr)
                mask <= '0;
            else if (all_mask_we)
                mask <= wdata[NCH-1:0];
            else if (one_mask_we)
                mask[wdata[CHW-1:0]] <= wdata[CHW];
        end
    end
endmodule

// File: rtl/dmac_hostif.sv
module dmac_hostif
    import dmac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic [NCH*RW-1:0]   eng_cur_addr,
    output logic [NCH*RW-1:0]   eng_cur_count,
    output logic [NCH*RW-1:0]   eng_base_addr,
    output logic [NCH*RW-1:0]   eng_base_count,
    output logic [NCH*MW-1:0]   eng_mode,
    output logic [NCH-1:0]      eng_mask,
    output logic [DW-1:0]       eng_cmd,
    output logic [DW-1:0]       eng_req,
    output logic [DW-1:0]       eng_status,
    input  logic                upd_we,
    input  logic [CHW-1:0]      upd_ch,
    input  logic [RW-1:0]       upd_addr,
    input  logic [RW-1:0]       upd_count,
    input  logic [DW-1:0]       sts_set,
    input  logic [DW-1:0]       sts_clr,
    input  logic                tmp_we,
    input  logic [DW-1:0]       tmp_data
);
    chan_regs_t    ch_regs [NCH];
    logic          byte_ptr;
    logic [DW-1:0] tmp_q;
    logic          ch_area;
    logic          ch_access;
    logic          ch_wr;

    assign ch_area   = ~bus_addr[3];
    assign ch_access = ch_area & (bus_rd | bus_wr);
    assign ch_wr     = ch_area & bus_wr;

    function automatic logic wr_at(input ctl_off_e o, input logic [3:0] a, input logic w);
        return w && (a == o);
    endfunction

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = ch_wr && (bus_addr[CHW:1] == CHW'(c));
        dmac_chan u_ch (
            .clk          (clk),
            .rst          (rst),
            .host_addr_we (hit && !bus_addr[0]),
            .host_cnt_we  (hit && bus_addr[0]),
            .ptr          (byte_ptr),
            .wdata        (bus_wdata),
            .mode_we      (wr_at(OFF_MODE, bus_addr, bus_wr) && (bus_wdata[CHW-1:0] == CHW'(c))),
            .mode_val     (bus_wdata[DW-1:CHW]),
            .upd_we       (upd_we && (upd_ch == CHW'(c))),
            .upd_addr     (upd_addr),
            .upd_count    (upd_count),
            .regs         (ch_regs[c])
        );
        assign eng_cur_addr[c*RW +: RW]   = ch_regs[c].cur_addr;
        assign eng_cur_count[c*RW +: RW]  = ch_regs[c].cur_cnt;
        assign eng_base_addr[c*RW +: RW]  = ch_regs[c].base_addr;
        assign eng_base_count[c*RW +: RW] = ch_regs[c].base_cnt;
        assign eng_mode[c*MW +: MW]       = ch_regs[c].mode;
    end

    dmac_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ch_access   (ch_access),
        .ptr_clr     (wr_at(OFF_PTR_CLR,  bus_addr, bus_wr)),
        .mrst        (wr_at(OFF_TMP_MRST, bus_addr, bus_wr)),
        .mask_clr    (wr_at(OFF_MASK_CLR, bus_addr, bus_wr)),
        .cmd_we      (wr_at(OFF_STAT_CMD, bus_addr, bus_wr)),
        .req_we      (wr_at(OFF_REQUEST,  bus_addr, bus_wr)),
        .one_mask_we (wr_at(OFF_ONE_MASK, bus_addr, bus_wr)),
        .all_mask_we (wr_at(OFF_ALL_MASK, bus_addr, bus_wr)),
        .wdata       (bus_wdata),
        .sts_set     (sts_set),
        .sts_clr     (sts_clr),
        .tmp_we      (tmp_we),
        .tmp_data    (tmp_data),
        .ptr         (byte_ptr),
        .cmd         (eng_cmd),
        .req         (eng_req),
        .status      (eng_status),
        .tmp         (tmp_q),
        .mask        (eng_mask)
    );

    always_comb begin
        chan_regs_t sel;
        sel = ch_regs[bus_addr[CHW:1]];
        bus_rdata = '1;
        if (ch_area)
            bus_rdata = get_byte(bus_addr[0] ? sel.cur_cnt : sel.cur_addr, byte_ptr);
        else begin
            case (bus_addr)
                OFF_STAT_CMD: bus_rdata = eng_status;
                OFF_TMP_MRST: bus_rdata = tmp_q;
                OFF_ALL_MASK: bus_rdata = {{(DW-NCH){1'b0}}, eng_mask};
                default:      bus_rdata = '1;
            endcase
        end
    end
endmodule

// File: rtl/dmac_hostif_chk.sv
module dmac_hostif_chk
    import dmac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [3:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DW-1:0]     bus_rdata,
    input logic              byte_ptr,
    input logic [NCH-1:0]    eng_mask,
    input logic [DW-1:0]     eng_cmd,
    input logic [DW-1:0]     eng_status,
    input logic [NCH*RW-1:0] eng_base_addr,
    input logic [NCH*RW-1:0] eng_base_count,
    input logic [DW-1:0]     sts_set
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (eng_mask == '1 && !byte_ptr && eng_cmd == '0 && eng_status == '0));

    a_r3_ptr_flips: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && !bus_addr[3]) |=> (byte_ptr != $past(byte_ptr)));

    a_r3_ptr_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_PTR_CLR) |=> !byte_ptr);

    a_r6_mask_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_MASK_CLR) |=> (eng_mask == '0));

    a_r7_master_reset: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_TMP_MRST) |=>
            (eng_mask == '1 && eng_cmd == '0 && eng_status == '0 && !byte_ptr));

    a_r8_unreadable_ff: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && (bus_addr == OFF_REQUEST || bus_addr == OFF_ONE_MASK ||
         bus_addr == OFF_MODE || bus_addr == OFF_PTR_CLR || bus_addr == OFF_MASK_CLR))
            |-> (bus_rdata == 8'hFF));

    a_r10_base_held: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && !bus_addr[3]) |=> ($stable(eng_base_addr) && $stable(eng_base_count)));

    a_r11_status_set: assert property (@(posedge clk) disable iff (rst)
        (sts_set != '0 && !(bus_wr && bus_addr == OFF_TMP_MRST)) |=>
            ((eng_status & $past(sts_set)) == $past(sts_set)));
endmodule

bind dmac_hostif dmac_hostif_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_rd         (bus_rd),
    .bus_rdata      (bus_rdata),
    .byte_ptr       (byte_ptr),
    .eng_mask       (eng_mask),
    .eng_cmd        (eng_cmd),
    .eng_status     (eng_status),
    .eng_base_addr  (eng_base_addr),
    .eng_base_count (eng_base_count),
    .sts_set        (sts_set)
);

// File: tb/dmac_hostif_tb.sv
module dmac_hostif_tb;
    import dmac_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [3:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic [NCH*RW-1:0] eng_cur_addr, eng_cur_count, eng_base_addr, eng_base_count;
    logic [NCH*MW-1:0] eng_mode;
    logic [NCH-1:0]    eng_mask;
    logic [DW-1:0]     eng_cmd, eng_req, eng_status;
    logic              upd_we = 1'b0;
    logic [CHW-1:0]    upd_ch = '0;
    logic [RW-1:0]     upd_addr = '0;
    logic [RW-1:0]     upd_count = '0;
    logic [DW-1:0]     sts_set = '0;
    logic [DW-1:0]     sts_clr = '0;
    logic              tmp_we = 1'b0;
    logic [DW-1:0]     tmp_data = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct { logic [7:0] exp; string tag; } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    dmac_hostif u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: compares each read against the scoreboard queue, mid low phase
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (bus_rd) begin
                if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
                else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    chk(it.tag, {24'h0, bus_rdata}, {24'h0, it.exp});
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog expired");
        if (!done) $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 mask", eng_mask, 4'hF);
        chk("R1 cmd", eng_cmd, 0);
        chk("R1 cur addr", eng_cur_addr[31:0], 0);
        chk("R1 mode", eng_mode, 0);
        host_rd(4'h8, 8'h00, "R1 status read");
        host_rd(4'h2, 8'h00, "R1 addr read");
        host_wr(4'hC, 8'h00);

        // R2: byte-serial load of base and current
        host_wr(4'h2, 8'h34);
        host_wr(4'h2, 8'h12);
        host_wr(4'h3, 8'hCD);
        host_wr(4'h3, 8'hAB);
        chk("R2 cur addr ch1", eng_cur_addr[1*16 +: 16], 16'h1234);
        chk("R2 base addr ch1", eng_base_addr[1*16 +: 16], 16'h1234);
        chk("R2 base count ch1", eng_base_count[1*16 +: 16], 16'hABCD);
        chk("R2 ch0 untouched", eng_cur_addr[15:0], 16'h0000);

        // R3: reads, pointer toggle and clear
        host_rd(4'h2, 8'h34, "R3 low byte");
        host_rd(4'h2, 8'h12, "R3 high byte");
        host_rd(4'h3, 8'hCD, "R3 count low");
        host_wr(4'hC, 8'h00);
        host_rd(4'h3, 8'hCD, "R3 after pointer clear");
        host_wr(4'hC, 8'h00);

        // R4: mode write to channel 2
        host_wr(4'hB, 8'hAE);
        chk("R4 mode ch2", eng_mode[2*6 +: 6], 6'h2B);
        chk("R4 mode ch1", eng_mode[1*6 +: 6], 6'h00);

        // R6 / R5: mask writes
        host_wr(4'hF, 8'hF5);
        host_rd(4'hF, 8'h05, "R6 all-mask readback");
        host_wr(4'hA, 8'h05);
        chk("R5 set ch1", eng_mask, 4'h7);
        host_wr(4'hA, 8'h02);
        chk("R5 clear ch2", eng_mask, 4'h3);
        host_wr(4'hE, 8'h00);
        chk("R6 mask clear", eng_mask, 4'h0);

        // R9: command, request, temporary
        host_wr(4'h8, 8'h44);
        chk("R9 command", eng_cmd, 8'h44);
        host_wr(4'h9, 8'h06);
        chk("R9 request", eng_req, 8'h06);
        @(negedge clk); tmp_we = 1'b1; tmp_data = 8'h5A;
        @(negedge clk); tmp_we = 1'b0;
        host_rd(4'hD, 8'h5A, "R9 temporary read");

        // R8: unreadable offsets, pointer unchanged
        host_rd(4'h9, 8'hFF, "R8 off9");
        host_rd(4'hA, 8'hFF, "R8 offA");
        host_rd(4'hB, 8'hFF, "R8 offB");
        host_rd(4'hC, 8'hFF, "R8 offC");
        host_rd(4'hE, 8'hFF, "R8 offE");
        host_rd(4'h2, 8'h34, "R8 pointer not moved");
        host_wr(4'hC, 8'h00);

        // R11: status set and clear from engine
        @(negedge clk); sts_set = 8'h22;
        @(negedge clk); sts_set = 8'h00; sts_clr = 8'h02;
        @(negedge clk); sts_clr = 8'h00;
        host_rd(4'h8, 8'h20, "R11 status set/clr");

        // R10: engine update leaves base alone
        @(negedge clk); upd_we = 1'b1; upd_ch = 2'd1; upd_addr = 16'h4000; upd_count = 16'h0010;
        @(negedge clk); upd_we = 1'b0;
        chk("R10 cur addr", eng_cur_addr[1*16 +: 16], 16'h4000);
        chk("R10 cur count", eng_cur_count[1*16 +: 16], 16'h0010);
        chk("R10 base kept", eng_base_addr[1*16 +: 16], 16'h1234);

        // R10 collision: engine update and host low byte in one cycle
        @(negedge clk);
        upd_we = 1'b1; upd_ch = 2'd1; upd_addr = 16'h9900; upd_count = 16'h0020;
        bus_addr = 4'h2; bus_wdata = 8'h77; bus_wr = 1'b1;
        @(negedge clk);
        upd_we = 1'b0; bus_wr = 1'b0;
        chk("R10 merged cur", eng_cur_addr[1*16 +: 16], 16'h9977);
        chk("R10 merged base", eng_base_addr[1*16 +: 16], 16'h1277);
        host_wr(4'hC, 8'h00);

        // R7 with R11 collision: master reset beats status set
        @(negedge clk);
        bus_addr = 4'hD; bus_wr = 1'b1; sts_set = 8'h01;
        @(negedge clk);
        bus_wr = 1'b0; sts_set = 8'h00;
        chk("R7 mask", eng_mask, 4'hF);
        chk("R7 cmd", eng_cmd, 0);
        chk("R7 req", eng_req, 0);
        chk("R7 channel kept", eng_cur_addr[1*16 +: 16], 16'h9977);
        chk("R7 mode kept", eng_mode[2*6 +: 6], 6'h2B);
        host_rd(4'h8, 8'h00, "R11 reset beats set");
        host_rd(4'hD, 8'h00, "R7 temporary cleared");
        host_rd(4'h2, 8'h77, "R7 pointer cleared");

        repeat (2) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule